// File: doc/BRIEF.md
# Twenty-Two Pin GPIO Port with Emergency Output Disable

This block is a general-purpose I/O port with twenty-two pins. Each pin has a direction bit and a function-select bit. It also has one data bit. The data bits are split over two register views: a low view that holds pins 0 to 15, and a high view that holds pins 16 to 21. A small register bus writes the four registers. The bus has a single-cycle write strobe, and read data comes back combinationally. For each pin, the block drives a tristate pair (output value and output enable) toward the pad.

The value read from a data bit depends on the pin's mode. For an input pin, the read returns the synchronized pin level. For an output pin, the read returns the stored bit. A pin that is an output and selected for an alternate function takes its value and enable from an alternate-function bus. A pin that is an output in general function drives its stored bit.

An active-low emergency input, once synchronized, removes the drive from a fixed set of high-current pins: 9 and 11 through 21. The stored data has no effect on this. All other pins keep driving.

Top module: `gpio_port_emdis`

## Requirements
- R1: After reset, all data, direction and function bits are 0. Every pad enable is 0. The data views read the synchronized pin levels, which are 0 right after reset.
- R2: In the high data view (address 0), bits 0 to 5 hold pins 16 to 21. Every bit above bit 5 reads as 0, and writes to those bits are dropped.
- R3: Address 2 is the direction register and address 3 is the function register. In both, bit p belongs to pin p. A direction bit of 1 makes the pin an output. A function bit of 1 selects the alternate function. A write with the strobe high updates the addressed register at that clock edge. Reading these registers returns the written bits 0 to 21, with 0 above.
- R4: In the low data view (address 1), bit 15-p belongs to pin p, for p from 0 to 15.
- R5: A pin with direction 0 reads back its synchronized input level, whatever its function bit. Its pad enable is 0.
- R6: A pin with direction 1 reads back its stored data bit, whatever its function bit and whatever its input level.
- R7: Data writes are stored whatever the pin's mode. A pin with direction 1 and function 0 drives its stored bit with its enable at 1.
- R8: A pin with direction 1 and function 1 takes its pad value from the alternate value input and its enable from the alternate enable input.
- R9: Two clock edges after the emergency input goes low, the enables of pins 9 and 11 to 21 are 0 in every mode. Pins 0 to 8 and 10 keep their enables. Two edges after the input returns high, the enables come back.
- R10: A change on a pin input shows up in a data read two clock edges later, and not after only one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 high data, 1 low data, 2 direction, 3 function |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_i | input | 22 | Raw pin levels, asynchronous |
| emerg_n_i | input | 1 | Active-low emergency output disable, asynchronous |
| alt_o_i | input | 22 | Alternate-function output values |
| alt_oe_i | input | 22 | Alternate-function output enables |
| pad_o | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables |

## Verification
The main sweep runs through three direction patterns, three function patterns and two pin-level patterns.

- The all-input and all-output patterns tell a read of the pin level apart from a read of the stored bit.
- The mixed patterns catch any swap between pins or between the register views.
- The all-alternate pattern, using alternate enables that differ from the stored data, tells the alternate source apart from the general-output source.

A walking one over the pins checks the bit order of both views. Separate sequences cover the following:
- the emergency input in general and in alternate output mode, sampled one and two edges after each change, which tells the affected pin set and the synchronizer latency apart;
- the latency of a pin input change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_DATA_HI = 2'd0,
      SEL_DATA_LO = 2'd1,
      SEL_DIR     = 2'd2,
      SEL_FUNC    = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 22,
   parameter int LO_BITS  = 16,
   parameter int HI_BITS  = 6,
   parameter int BUS_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          addr,
   input  logic [BUS_W-1:0]    wdata,
   input  logic [NUM_PINS-1:0] pin_sync,
   output logic [NUM_PINS-1:0] dat_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] func_q,
   output logic [BUS_W-1:0]    rdata
);

   logic [NUM_PINS-1:0] pin_view;
   reg_sel_e            sel;

   assign sel = reg_sel_e'(addr);

   if (BUS_W > NUM_PINS) begin : g_spare_bits
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[BUS_W-1:NUM_PINS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q  <= '0;
         dir_q  <= '0;
         func_q <= '0;
      end else if (we) begin
         unique case (sel)
            SEL_DATA_LO: for (int i = 0; i < LO_BITS; i++) dat_q[i] <= wdata[LO_BITS-1-i];
            SEL_DATA_HI: for (int k = 0; k < HI_BITS; k++) dat_q[LO_BITS+k] <= wdata[k];
            SEL_DIR:     dir_q  <= wdata[NUM_PINS-1:0];
            SEL_FUNC:    func_q <= wdata[NUM_PINS-1:0];
            default:     ;
         endcase
      end
   end

   // output pins read the stored bit, input pins read the synchronized level
   assign pin_view = (dir_q & dat_q) | (~dir_q & pin_sync);

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_DATA_LO: for (int i = 0; i < LO_BITS; i++) rdata[LO_BITS-1-i] = pin_view[i];
         SEL_DATA_HI: for (int k = 0; k < HI_BITS; k++) rdata[k] = pin_view[LO_BITS+k];
         SEL_DIR:     rdata[NUM_PINS-1:0] = dir_q;
         SEL_FUNC:    rdata[NUM_PINS-1:0] = func_q;
         default:     ;
      endcase
   end

   assert_hi_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_DATA_HI) |-> (rdata[BUS_W-1:HI_BITS] == '0));

   assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_DIR) |=> (dir_q == $past(wdata[NUM_PINS-1:0])));

   assert_func_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_FUNC) |=> (func_q == $past(wdata[NUM_PINS-1:0])));

   assert_dat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!we) |=> $stable(dat_q));

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
   parameter int                  NUM_PINS = 22,
   parameter logic [NUM_PINS-1:0] HC_MASK  = '0
) (
   input  logic [NUM_PINS-1:0] dat_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] func_q,
   input  logic [NUM_PINS-1:0] alt_o,
   input  logic [NUM_PINS-1:0] alt_oe,
   input  logic                dis_n,
   output logic [NUM_PINS-1:0] pad_o,
   output logic [NUM_PINS-1:0] pad_oe
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic gate;
      if (HC_MASK[p]) begin : g_high_current
         assign gate = dis_n;
      end else begin : g_plain
         assign gate = 1'b1;
      end
      assign pad_oe[p] = dir_q[p] & (func_q[p] ? alt_oe[p] : 1'b1) & gate;
      assign pad_o[p]  = dir_q[p] & (func_q[p] ? alt_o[p] : dat_q[p]);
   end

endmodule

// File: rtl/gpio_port_emdis.sv
module gpio_port_emdis
   import gpio_port_pkg::*;
#(
   parameter int                  NUM_PINS    = 22,
   parameter int                  LO_BITS     = 16,
   parameter int                  HI_BITS     = 6,
   parameter int                  BUS_W       = 32,
   parameter int                  SYNC_STAGES = 2,
   parameter logic [NUM_PINS-1:0] HC_MASK     = 22'h3F_FA00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [1:0]          reg_addr,
   input  logic [BUS_W-1:0]    reg_wdata,
   output logic [BUS_W-1:0]    reg_rdata,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                emerg_n_i,
   input  logic [NUM_PINS-1:0] alt_o_i,
   input  logic [NUM_PINS-1:0] alt_oe_i,
   output logic [NUM_PINS-1:0] pad_o,
   output logic [NUM_PINS-1:0] pad_oe
);

   localparam int SW = NUM_PINS + 1;

   if (LO_BITS + HI_BITS != NUM_PINS) begin : g_bad_split
      $error("gpio_port_emdis: LO_BITS + HI_BITS must equal NUM_PINS");
   end
   if (BUS_W < NUM_PINS) begin : g_bad_bus
      $error("gpio_port_emdis: BUS_W must cover NUM_PINS");
   end
   if (HI_BITS > LO_BITS) begin : g_bad_hi
      $error("gpio_port_emdis: HI_BITS must not exceed LO_BITS");
   end

   logic [SW-1:0]       sync_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic                dis_n;
   logic [NUM_PINS-1:0] dat_q, dir_q, func_q;

   gpio_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({1'b1, {NUM_PINS{1'b0}}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({emerg_n_i, pin_i}),
      .q     (sync_q)
   );

   assign pin_sync = sync_q[NUM_PINS-1:0];
   assign dis_n    = sync_q[NUM_PINS];

   gpio_regs #(
      .NUM_PINS (NUM_PINS),
      .LO_BITS  (LO_BITS),
      .HI_BITS  (HI_BITS),
      .BUS_W    (BUS_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .pin_sync (pin_sync),
      .dat_q    (dat_q),
      .dir_q    (dir_q),
      .func_q   (func_q),
      .rdata    (reg_rdata)
   );

   gpio_drive #(
      .NUM_PINS (NUM_PINS),
      .HC_MASK  (HC_MASK)
   ) u_drive (
      .dat_q  (dat_q),
      .dir_q  (dir_q),
      .func_q (func_q),
      .alt_o  (alt_o_i),
      .alt_oe (alt_oe_i),
      .dis_n  (dis_n),
      .pad_o  (pad_o),
      .pad_oe (pad_oe)
   );

   logic [1:0] settle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                settle_q <= '0;
      else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
   end

   assert_input_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_q) == '0);

   if (SYNC_STAGES == 2) begin : g_emerg_chk
      assert_emerg_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (settle_q == 2'd3 && !$past(emerg_n_i) && !$past(emerg_n_i, 2))
            |-> ((pad_oe & HC_MASK) == '0));
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_plain_chk
      if (!HC_MASK[p]) begin : g_chk
         assert_plain_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_q[p] && !func_q[p]) |-> pad_oe[p]);
      end
   end

endmodule

// File: tb/test_gpio_port_emdis.sv
module test_gpio_port_emdis;

   localparam logic [21:0] HC   = 22'h3F_FA00;
   localparam logic [21:0] ALL1 = 22'h3F_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [21:0] pin_i = '0;
   logic        emerg_n_i = 1'b1;
   logic [21:0] alt_o_i = '0;
   logic [21:0] alt_oe_i = '0;
   logic [21:0] pad_o, pad_oe;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   gpio_port_emdis i_gpio_port_emdis (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .pin_i, .emerg_n_i, .alt_o_i, .alt_oe_i, .pad_o, .pad_oe
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   function automatic logic [31:0] to_lo(input logic [21:0] v);
      logic [31:0] r = '0;
      for (int i = 0; i < 16; i++) r[15-i] = v[i];
      return r;
   endfunction

   function automatic logic [31:0] to_hi(input logic [21:0] v);
      return {26'd0, v[21:16]};
   endfunction

   task automatic wr_data(input logic [21:0] v);
      wr(2'd1, to_lo(v));
      wr(2'd0, to_hi(v));
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      logic [21:0] dirs  [3];
      logic [21:0] funcs [3];
      logic [21:0] pins  [2];
      logic [21:0] m_dat;
      dirs[0]  = '0;    dirs[1]  = ALL1;  dirs[2]  = 22'h15_5555;
      funcs[0] = '0;    funcs[1] = ALL1;  funcs[2] = 22'h0C_CCCC;
      pins[0]  = 22'h2A_AAAA;  pins[1] = 22'h03_C3C3;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         chk("R1", "reset read", v, 32'd0);
      end
      chk("R1", "reset pad_oe", {10'd0, pad_oe}, 32'd0);

      // R3 direction and function readback
      wr(2'd2, 32'hFFC1_2345);
      rd(2'd2, v); chk("R3", "dir readback", v, 32'h0001_2345);
      wr(2'd3, 32'h803A_BCDE);
      rd(2'd3, v); chk("R3", "func readback", v, 32'h003A_BCDE);

      // R2 high view upper bits
      wr(2'd2, 32'h003F_FFFF);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); chk("R2", "hi upper bits dropped", v, 32'h0000_003F);

      // R7 writes kept while input, visible once output
      wr(2'd2, 32'd0);
      wr(2'd3, 32'd0);
      wr_data(22'h1F_00F1);
      wr(2'd2, 32'h003F_FFFF);
      rd(2'd1, v); chk("R7", "lo data written as input", v, to_lo(22'h1F_00F1));
      rd(2'd0, v); chk("R7", "hi data written as input", v, to_hi(22'h1F_00F1));
      chk("R7", "general output drive", {10'd0, pad_o}, {10'd0, 22'h1F_00F1});

      // R4 walking one over pin inputs
      wr(2'd2, 32'd0);
      for (int p = 0; p < 22; p++) begin
         pin_i = 22'd1 << p;
         settle();
         rd(2'd1, v);
         chk("R4", $sformatf("walk lo pin %0d", p), v, to_lo(pin_i));
         rd(2'd0, v);
         chk("R4", $sformatf("walk hi pin %0d", p), v, to_hi(pin_i));
      end

      // R10 input latency
      pin_i = '0;
      settle();
      @(negedge clk);
      pin_i = 22'd1;
      @(negedge clk);
      rd(2'd1, v); chk("R10", "one edge, old level", v, 32'd0);
      @(negedge clk);
      rd(2'd1, v); chk("R10", "two edges, new level", v, 32'h0000_8000);

      // R5 R6 R7 R8 mode sweep
      m_dat   = 22'h35_A5C3;
      alt_o_i  = 22'h0F_0F0F;
      alt_oe_i = 22'h33_3333;
      wr_data(m_dat);
      for (int d = 0; d < 3; d++) begin
         for (int f = 0; f < 3; f++) begin
            wr(2'd2, {10'd0, dirs[d]});
            wr(2'd3, {10'd0, funcs[f]});
            for (int q = 0; q < 2; q++) begin
               logic [21:0] view, eoe, eo;
               pin_i = pins[q];
               settle();
               view = (dirs[d] & m_dat) | (~dirs[d] & pins[q]);
               eoe  = dirs[d] & (~funcs[f] | alt_oe_i);
               eo   = dirs[d] & ((funcs[f] & alt_o_i) | (~funcs[f] & m_dat));
               rd(2'd1, v); chk("R5/R6", "sweep lo read", v, to_lo(view));
               rd(2'd0, v); chk("R5/R6", "sweep hi read", v, to_hi(view));
               chk("R5/R8", "sweep pad_oe", {10'd0, pad_oe}, {10'd0, eoe});
               chk("R7/R8", "sweep pad_o", {10'd0, pad_o & eoe}, {10'd0, eo & eoe});
            end
         end
      end

      // R9 emergency disable, general output
      wr(2'd2, 32'h003F_FFFF);
      wr(2'd3, 32'd0);
      wr_data(ALL1);
      emerg_n_i = 1'b0;
      @(negedge clk);
      chk("R9", "gen one edge after low", {10'd0, pad_oe}, {10'd0, ALL1});
      @(negedge clk);
      chk("R9", "gen two edges after low", {10'd0, pad_oe}, {10'd0, ~HC});
      chk("R9", "data still stored", {10'd0, pad_o}, {10'd0, ALL1});
      // alternate mode while disabled
      alt_oe_i = ALL1;
      wr(2'd3, 32'h003F_FFFF);
      chk("R9", "alt while low", {10'd0, pad_oe}, {10'd0, ~HC});
      emerg_n_i = 1'b1;
      @(negedge clk);
      chk("R9", "one edge after release", {10'd0, pad_oe}, {10'd0, ~HC});
      @(negedge clk);
      chk("R9", "two edges after release", {10'd0, pad_oe}, {10'd0, ALL1});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule